// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Entry Status FIFO

This block receives asynchronous serial frames on a single input line. An external baud generator supplies a one-cycle tick at a fixed multiple of the bit rate. The receiver finds the start bit and shifts in eight or nine data bits, least significant bit first. It then checks the stop bit and hands the finished frame to a two-entry holding FIFO. Each FIFO entry stores the data byte, the ninth bit and a framing-error flag. The consumer therefore always sees the status that belongs to the byte at the head, and a single read strobe retires data and status together.

The receiver runs only while its enable input is high. If a frame completes while both FIFO entries are occupied, a sticky overrun flag is raised and the frame is dropped. From then on no frame enters the FIFO until the enable is taken low and raised again. The two entries already queued stay readable through the overrun and through any disable.

Top module: `rxs_top`

## Requirements
- R1: After reset, `rd_avail` and `rd_overrun` are both 0.
- R2: With `nine_bit`=0 a frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. The byte appears on `rd_data` and `rd_bit9` reads 0.
- R3: With `nine_bit`=1 the frame carries nine data bits before the stop bit. The first eight form `rd_data` and the ninth appears on `rd_bit9` of the same entry.
- R4: Each bit is decided by a majority of three samples. In 16x mode these are taken at ticks 7, 8 and 9 of the bit, counting the tick that first sees the start edge as tick 0. A single corrupted sample at tick 8 does not change the received bit.
- R5: A falling edge whose majority vote at mid start bit reads high is treated as noise. The receiver returns to idle and no entry is stored.
- R6: A frame whose stop bit is voted 0 is still stored, with `rd_ferr`=1. A frame with a stop bit voted 1 has `rd_ferr`=0.
- R7: The FIFO holds two entries in arrival order. `rd_data`, `rd_bit9` and `rd_ferr` always show the head entry, and a one-cycle `rd_pop` removes all three together.
- R8: `rd_avail` is 1 whenever at least one entry is held and returns to 0 after the last entry is popped. A pop while the FIFO is empty has no effect.
- R9: A frame that completes while both entries are occupied sets `rd_overrun` and is discarded. The two stored entries are kept unchanged.
- R10: While `rd_overrun` is 1, completed frames are discarded even when the FIFO has room again. The flag clears only while `rx_en` is 0, and reception resumes after `rx_en` returns to 1.
- R11: While `rx_en` is 0 the line is ignored. Lowering `rx_en` during a frame aborts that frame. Entries already in the FIFO stay readable.
- R12: With `osr_sel`=1 a bit lasts 64 ticks and the three votes are taken at ticks 28, 32 and 36. `osr_sel` and `nine_bit` are captured when the start edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable. Low resets the frame logic and clears overrun |
| osr_sel | input | 1 | 0: 16 ticks per bit, 1: 64 ticks per bit |
| nine_bit | input | 1 | 1: nine data bits per frame, 0: eight |
| os_tick | input | 1 | Oversampling tick from the external baud generator, one cycle wide |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rd_pop | input | 1 | Removes the head entry |
| rd_data | output | 8 | Data byte of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_ferr | output | 1 | Framing-error flag of the head entry |
| rd_avail | output | 1 | At least one entry is held |
| rd_overrun | output | 1 | Sticky overrun flag |

## Verification
Some properties are checked on every cycle. The FIFO count never exceeds two, and popping an empty FIFO leaves it empty. A completed frame only ever leaves the stop-bit state, and the FIFO never grows while overrun is set. Overrun is raised only from a full FIFO and is clear whenever the enable is low. Other behaviour can only be shown by the bench's scenarios. These scenarios cover bit order and the ninth bit, tolerance to a single bad mid-bit sample, rejection of short start pulses, and framing errors that travel with their own byte. They also cover dropped frames during overrun, recovery after toggling the enable, an aborted frame, and the 64x rate.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              ferr;
    logic              bit9;
    logic [DATA_W-1:0] data;
  } rxs_entry_t;

  localparam int ENTRY_W = $bits(rxs_entry_t);

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_DATA  = 2'd2,
    S_STOP  = 2'd3
  } rxs_state_t;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rxs_frame.sv
module rxs_frame
  import rxs_pkg::*;
#(
  parameter int OSR_LO = 16,
  parameter int OSR_HI = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       line,
  input  logic       osr_sel,
  input  logic       nine_sel,
  output logic       fr_valid,
  output rxs_entry_t fr_entry
);
  localparam int CW = $clog2(OSR_HI);
  localparam int IW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] LO_LAST = CW'(OSR_LO - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(OSR_HI - 1);
  localparam logic [CW-1:0] LO_S1   = CW'(OSR_LO / 2);
  localparam logic [CW-1:0] HI_S1   = CW'(OSR_HI / 2);
  localparam logic [CW-1:0] LO_S0   = CW'(OSR_LO / 2 - OSR_LO / 16);
  localparam logic [CW-1:0] HI_S0   = CW'(OSR_HI / 2 - OSR_HI / 16);
  localparam logic [CW-1:0] LO_S2   = CW'(OSR_LO / 2 + OSR_LO / 16);
  localparam logic [CW-1:0] HI_S2   = CW'(OSR_HI / 2 + OSR_HI / 16);

  rxs_state_t      state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic [DATA_W:0] sr;
  logic [1:0]      votes;
  logic            prev;
  logic            osr_q;
  logic            nine_q;

  logic [CW-1:0]   last_c, s0_c, s1_c, s2_c;
  logic [IW-1:0]   top_idx;
  logic            maj;

  always_comb begin
    last_c  = osr_q ? HI_LAST : LO_LAST;
    s0_c    = osr_q ? HI_S0   : LO_S0;
    s1_c    = osr_q ? HI_S1   : LO_S1;
    s2_c    = osr_q ? HI_S2   : LO_S2;
    top_idx = nine_q ? IW'(DATA_W) : IW'(DATA_W - 1);
    maj     = (votes[0] & votes[1]) | (votes[0] & line) | (votes[1] & line);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state    <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sr       <= '0;
      votes    <= '0;
      prev     <= 1'b0;
      osr_q    <= 1'b0;
      nine_q   <= 1'b0;
      fr_valid <= 1'b0;
      fr_entry <= '0;
    end else begin
      fr_valid <= 1'b0;
      if (tick) begin
        prev <= line;
        if (state == S_IDLE) begin
          if (prev && !line) begin
            state  <= S_START;
            cnt    <= CW'(1);
            idx    <= '0;
            sr     <= '0;
            osr_q  <= osr_sel;
            nine_q <= nine_sel;
          end
        end else begin
          if (cnt == s0_c) votes[0] <= line;
          if (cnt == s1_c) votes[1] <= line;
          if (cnt == s2_c) begin
            case (state)
              S_START: if (maj) state <= S_IDLE;
              S_DATA:  sr[idx] <= maj;
              S_STOP: begin
                fr_valid      <= 1'b1;
                fr_entry.data <= sr[DATA_W-1:0];
                fr_entry.bit9 <= nine_q & sr[DATA_W];
                fr_entry.ferr <= ~maj;
                state         <= S_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt == last_c) begin
            cnt <= '0;
            if (state == S_START) begin
              state <= S_DATA;
              idx   <= '0;
            end else if (state == S_DATA) begin
              if (idx == top_idx) state <= S_STOP;
              else                idx   <= idx + IW'(1);
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end

  // R2
  frame_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
    fr_valid |-> $past(state) == S_STOP);

  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == S_IDLE && !fr_valid));
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  rxs_entry_t                   wr_entry,
  input  logic                         pop,
  output rxs_entry_t                   head,
  output logic                         full,
  output logic                         nonempty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  rxs_entry_t    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CNW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && (cnt != CNW'(DEPTH));

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CNW'(1);
        2'b01:   cnt <= cnt - CNW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign head     = mem[rp];
  assign full     = (cnt == CNW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign level    = cnt;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNW'(DEPTH));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/rxs_top.sv
module rxs_top
  import rxs_pkg::*;
#(
  parameter int OSR_LO      = 16,
  parameter int OSR_HI      = 64,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              osr_sel,
  input  logic              nine_bit,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              rd_avail,
  output logic              rd_overrun
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic       line_s;
  logic       fr_valid;
  rxs_entry_t fr_entry;
  rxs_entry_t head;
  logic       full, nonempty, push;
  logic [LW-1:0] level;
  logic       ovr;

  rxs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_in(rx_in), .d_out(line_s)
  );

  rxs_frame #(.OSR_LO(OSR_LO), .OSR_HI(OSR_HI)) u_frame (
    .clk(clk), .rst(rst), .en(rx_en), .tick(os_tick), .line(line_s),
    .osr_sel(osr_sel), .nine_sel(nine_bit),
    .fr_valid(fr_valid), .fr_entry(fr_entry)
  );

  assign push = fr_valid && !ovr && !full;

  always_ff @(posedge clk) begin
    if (rst || !rx_en)                ovr <= 1'b0;
    else if (fr_valid && !ovr && full) ovr <= 1'b1;
  end

  rxs_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wr_entry(fr_entry), .pop(rd_pop),
    .head(head), .full(full), .nonempty(nonempty), .level(level)
  );

  assign rd_data    = head.data;
  assign rd_bit9    = head.bit9;
  assign rd_ferr    = head.ferr;
  assign rd_avail   = nonempty;
  assign rd_overrun = ovr;

  // R9
  ovr_from_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(full));

  // R10
  ovr_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
    ovr |=> level <= $past(level));

  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !ovr);
endmodule

// File: tb/tb_rxs_top.sv
module tb_rxs_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       osr_sel = 1'b0;
  logic       nine_bit = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_ferr, rd_avail, rd_overrun;

  int checks = 0;
  int errors = 0;
  int tdiv = 0;

  logic [9:0] mq [2];
  int         mn = 0;
  bit         movr = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == 2) ? 0 : tdiv + 1;
    os_tick <= (tdiv == 2);
  end

  rxs_top dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .osr_sel(osr_sel), .nine_bit(nine_bit),
    .os_tick(os_tick), .rx_in(rx_in), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_bit9(rd_bit9), .rd_ferr(rd_ferr), .rd_avail(rd_avail), .rd_overrun(rd_overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_frame(input logic [8:0] d, input bit nine, input bit stopv);
    logic [9:0] e;
    e = {~stopv, nine ? d[8] : 1'b0, d[7:0]};
    if (!movr) begin
      if (mn == 2) movr = 1'b1;
      else begin
        mq[mn] = e;
        mn++;
      end
    end
  endfunction

  task automatic wait_tick();
    @(posedge clk);
    while (!os_tick) @(posedge clk);
    #1;
  endtask

  task automatic hold(input bit v, input int n);
    rx_in = v;
    for (int t = 0; t < n; t++) wait_tick();
  endtask

  task automatic send_frame(input logic [8:0] d, input bit nine, input bit stopv,
                            input int gbit, input int osr);
    int nb;
    bit val;
    nb = nine ? 9 : 8;
    osr_sel  = (osr == 64);
    nine_bit = nine;
    for (int b = 0; b < nb + 2; b++) begin
      if (b == 0)       val = 1'b0;
      else if (b <= nb) val = d[b-1];
      else              val = stopv;
      for (int t = 0; t < osr; t++) begin
        rx_in = (b == gbit && t == osr / 2) ? ~val : val;
        wait_tick();
      end
    end
    hold(1'b1, 3);
  endtask

  task automatic pop_chk(input string tag);
    @(negedge clk);
    check({tag, " avail"}, rd_avail, (mn > 0));
    check({tag, " overrun"}, rd_overrun, movr);
    if (mn > 0) begin
      check({tag, " data"}, rd_data, mq[0][7:0]);
      check({tag, " bit9"}, rd_bit9, mq[0][8]);
      check({tag, " ferr"}, rd_ferr, mq[0][9]);
      mq[0] = mq[1];
      mn--;
    end
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic toggle_en();
    @(negedge clk);
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    movr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int junk;
    logic [8:0] d;
    bit nine, stopv;
    int g, np;
    junk = $urandom(32'd20517);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 avail", rd_avail, 1'b0);
    check("R1 overrun", rd_overrun, 1'b0);
    rx_en = 1'b1;
    hold(1'b1, 4);

    // R8: pop on empty
    pop_chk("R8 empty pop");
    check("R8 still empty", rd_avail, 1'b0);

    // R2
    send_frame(9'h0A5, 1'b0, 1'b1, -1, 16); model_frame(9'h0A5, 1'b0, 1'b1);
    pop_chk("R2");
    // R3
    send_frame(9'h13C, 1'b1, 1'b1, -1, 16); model_frame(9'h13C, 1'b1, 1'b1);
    pop_chk("R3");
    // R4: glitch at mid of data bit 0 and on start bit
    send_frame(9'h00F, 1'b0, 1'b1, 1, 16); model_frame(9'h00F, 1'b0, 1'b1);
    pop_chk("R4 data glitch");
    send_frame(9'h0C3, 1'b0, 1'b1, 0, 16); model_frame(9'h0C3, 1'b0, 1'b1);
    pop_chk("R4 start glitch");

    // R5: short low pulse
    hold(1'b0, 4);
    hold(1'b1, 40);
    @(negedge clk);
    check("R5 no entry", rd_avail, 1'b0);

    // R6
    send_frame(9'h081, 1'b0, 1'b0, -1, 16); model_frame(9'h081, 1'b0, 1'b0);
    pop_chk("R6 ferr");

    // R7: ordering and per-entry status
    send_frame(9'h055, 1'b0, 1'b0, -1, 16); model_frame(9'h055, 1'b0, 1'b0);
    send_frame(9'h1AA, 1'b1, 1'b1, -1, 16); model_frame(9'h1AA, 1'b1, 1'b1);
    pop_chk("R7 first");
    pop_chk("R7 second");
    @(negedge clk);
    check("R8 drained", rd_avail, 1'b0);

    // R9 / R10
    send_frame(9'h011, 1'b0, 1'b1, -1, 16); model_frame(9'h011, 1'b0, 1'b1);
    send_frame(9'h022, 1'b0, 1'b1, -1, 16); model_frame(9'h022, 1'b0, 1'b1);
    send_frame(9'h033, 1'b0, 1'b1, -1, 16); model_frame(9'h033, 1'b0, 1'b1);
    @(negedge clk);
    check("R9 overrun set", rd_overrun, 1'b1);
    pop_chk("R9 keep first");
    send_frame(9'h044, 1'b0, 1'b1, -1, 16); model_frame(9'h044, 1'b0, 1'b1);
    pop_chk("R10 dropped while overrun");
    @(negedge clk);
    check("R10 empty", rd_avail, 1'b0);
    toggle_en();
    check("R10 cleared", rd_overrun, 1'b0);
    hold(1'b1, 2);
    send_frame(9'h066, 1'b0, 1'b1, -1, 16); model_frame(9'h066, 1'b0, 1'b1);
    pop_chk("R10 resumed");

    // R11: disabled line ignored, abort mid frame, FIFO retained
    send_frame(9'h05A, 1'b0, 1'b1, -1, 16); model_frame(9'h05A, 1'b0, 1'b1);
    @(negedge clk);
    rx_en = 1'b0;
    send_frame(9'h000, 1'b0, 1'b1, -1, 16);
    rx_en = 1'b1;
    hold(1'b1, 2);
    hold(1'b0, 16);
    hold(1'b1, 2);
    @(negedge clk);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    hold(1'b1, 150);
    pop_chk("R11 retained");
    @(negedge clk);
    check("R11 nothing added", rd_avail, 1'b0);

    // R12
    send_frame(9'h1B7, 1'b1, 1'b1, 3, 64); model_frame(9'h1B7, 1'b1, 1'b1);
    pop_chk("R12 x64");
    send_frame(9'h04E, 1'b0, 1'b0, 0, 64); model_frame(9'h04E, 1'b0, 1'b0);
    pop_chk("R12 x64 ferr");

    // random mix
    for (int i = 0; i < 30; i++) begin
      d     = 9'($urandom());
      nine  = 1'($urandom() % 2);
      stopv = (($urandom() % 4) != 0);
      g     = (($urandom() % 3) == 0) ? int'($urandom() % 9) : -1;
      send_frame(d, nine, stopv, g, 16);
      model_frame(d, nine, stopv);
      if (!stopv) hold(1'b1, 2);
      @(negedge clk);
      check("R9 random overrun", rd_overrun, movr);
      np = int'($urandom() % 3);
      for (int k = 0; k < np; k++) pop_chk("R7 random");
      if (movr && ($urandom() % 2 == 1)) toggle_en();
    end
    while (mn > 0) pop_chk("R7 drain");
    finish_run();
  end
endmodule